// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Poke Reload

This block is a single watchdog timer on a simple register bus. A power-of-two prescaler divides the clock, 1024 by default. Each prescaler tick moves a 24-bit down-counter one step. Software arms the timer with a 64-bit control word that holds an enable mode, a 16-bit length and an optional starting count. The length gives the top 16 bits of the 24-bit reload value. A write to a second address, the poke address, restarts the current period. If the count runs out before software pokes, the block raises a one-cycle expiry pulse and starts the next period from the length.

A three-state machine controls the sequencing. OFF is idle: the count is frozen and the prescaler is held at zero. RUN counts. FIRED lasts one cycle and drives the expiry pulse while counting goes on. The named transitions are as follows. Arm (OFF to RUN) is a control write with a nonzero mode and a nonzero length. Disarm (RUN or FIRED to OFF) is a control write that does not meet the arm condition. Expire (RUN to FIRED) happens on a tick while the count is 1 or 0. Resume (FIRED to RUN) happens on the next cycle when no further expiry occurs. Every bus write, to either address, clears the prescaler, so each period is an exact number of clock cycles.

Top module: `wdt_core`

## Requirements
- R1: After a synchronous active-high reset, expire is low, the control word reads as all zeros and the watchdog is disabled.
- R2: The control word is at offset 0x00000 and uses these fields: mode in bits 1:0, length in bits 19:4 and count in bits 43:20. A control write stores all three fields. A control read returns the stored mode, the stored length and the live count in those positions, with every other bit zero. Reads of the poke offset 0x10000 return zero.
- R3: The watchdog counts when mode is 1, 2 or 3, and these three values behave the same. Mode 0 keeps it idle.
- R4: While armed, the count drops by one every 2^PRE_LOG2 clock cycles. It stays unchanged between ticks, and the first tick comes 2^PRE_LOG2 cycles after the last bus write.
- R5: After an arming write with count N, the first expiry comes N·2^PRE_LOG2 cycles after the write edge. A written count of 0 expires at the first tick.
- R6: On expiry, expire is high for exactly one cycle, and in that cycle the count reads as length shifted left by 8, with the low 8 bits zero.
- R7: Any write to the poke offset 0x10000 reloads the count with length shifted left by 8 and restarts the prescaler. The write data has no effect.
- R8: A control write of all zeros stops the watchdog: no expiry follows, and the control word reads as zero.
- R9: A control write with a nonzero mode and a length of zero leaves the watchdog idle, with the written count frozen.
- R10: After an expiry, each later period lasts (length·256)·2^PRE_LOG2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (20) | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (64) | Write data |
| bus_rdata | output | DATA_W (64) | Read data for bus_addr, combinational |
| expire | output | 1 | One-cycle expiry pulse |

## Verification
If the prescaler phase is wrong, the first expiry moves by up to 2^PRE_LOG2 cycles. The bench counts cycles from the write edge to the pulse, so it sees this on the first period. A wrong count or reload value shows up in the readback of bits 43:20 at the expiry cycle, or as a later period of the wrong length. If the machine is stuck in FIRED or in OFF, the result is a pulse longer than one cycle, or no pulse at all within the expected window, and a stuck FIRED is visible one cycle later.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_FIRED = 2'd2
    } wdt_state_e;

    localparam int MODE_W  = 2;
    localparam int LEN_LSB = 4;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRE_LOG2 = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic tick
);

    generate
        if (PRE_LOG2 == 0) begin : g_bypass
            assign tick = run && !clr;
        end else begin : g_div
            logic [PRE_LOG2-1:0] phase_q;

            always_ff @(posedge clk) begin
                if (rst || clr || !run) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end

            assign tick = run && !clr && (&phase_q);
        end
    endgenerate

endmodule

// File: rtl/wdt_regif.sv
module wdt_regif
    import wdt_pkg::*;
#(
    parameter int                ADDR_W   = 20,
    parameter int                DATA_W   = 64,
    parameter int                LEN_W    = 16,
    parameter int                CNT_W    = 24,
    parameter logic [ADDR_W-1:0] CTRL_OFS = '0,
    parameter logic [ADDR_W-1:0] POKE_OFS = ADDR_W'(20'h10000)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_live,
    output logic              ctrl_wr,
    output logic              poke_wr,
    output logic [MODE_W-1:0] wr_mode,
    output logic [LEN_W-1:0]  wr_len,
    output logic [CNT_W-1:0]  wr_cnt,
    output logic [LEN_W-1:0]  len_q,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int CNT_LSB = LEN_LSB + LEN_W;

    logic [MODE_W-1:0] mode_q;
    logic              unused_wbits;

    assign ctrl_wr = bus_wr && (bus_addr == CTRL_OFS);
    assign poke_wr = bus_wr && (bus_addr == POKE_OFS);

    assign wr_mode = bus_wdata[MODE_W-1:0];
    assign wr_len  = bus_wdata[LEN_LSB +: LEN_W];
    assign wr_cnt  = bus_wdata[CNT_LSB +: CNT_W];

    assign unused_wbits = ^{bus_wdata[LEN_LSB-1:MODE_W],
                            bus_wdata[DATA_W-1:CNT_LSB+CNT_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            len_q  <= '0;
        end else if (ctrl_wr) begin
            mode_q <= wr_mode;
            len_q  <= wr_len;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_OFS) begin
            bus_rdata[MODE_W-1:0]          = mode_q;
            bus_rdata[LEN_LSB +: LEN_W]    = len_q;
            bus_rdata[CNT_LSB +: CNT_W]    = cnt_live;
        end
    end

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int CNT_W    = 24,
    parameter int PRE_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              poke_wr,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [CNT_W-1:0]  wr_cnt,
    input  logic [LEN_W-1:0]  len_q,
    input  logic              tick,
    output logic              run,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              expire
);

    localparam int SHIFT = CNT_W - LEN_W;

    wdt_state_e       st_q, st_d;
    logic [CNT_W-1:0] reload;
    logic             arm_req;
    logic             last_step;

    assign reload    = {len_q, {SHIFT{1'b0}}};
    assign arm_req   = (wr_mode != '0) && (wr_len != '0);
    assign last_step = (cnt_q <= CNT_W'(1));
    assign run       = (st_q != ST_OFF);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF: begin
                if (ctrl_wr && arm_req) st_d = ST_RUN;
            end
            ST_RUN, ST_FIRED: begin
                if (ctrl_wr)                st_d = arm_req ? ST_RUN : ST_OFF;
                else if (tick && last_step) st_d = ST_FIRED;
                else                        st_d = ST_RUN;
            end
            default: st_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_OFF;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ctrl_wr) begin
            cnt_q <= wr_cnt;
        end else if (poke_wr) begin
            cnt_q <= reload;
        end else if (run && tick) begin
            cnt_q <= last_step ? reload : (cnt_q - CNT_W'(1));
        end
    end

    always_comb begin
        expire = (st_q == ST_FIRED);
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && tick && cnt_q > CNT_W'(1) && !ctrl_wr && !poke_wr)
        |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R4
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ctrl_wr && !poke_wr) |=> $stable(cnt_q)); // R4
    AST_POKE_RELOAD: assert property (@(posedge clk) disable iff (rst)
        poke_wr |=> cnt_q == $past(reload)); // R7
    AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (rst)
        expire |-> cnt_q == reload); // R6
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_OFF && !ctrl_wr) |=> !expire); // R8

    generate
        if (PRE_LOG2 > 0) begin : g_pulse_chk
            AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
                expire |=> !expire); // R6
        end
    endgenerate

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 64,
    parameter int LEN_W    = 16,
    parameter int CNT_W    = 24,
    parameter int PRE_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              expire
);

    logic              ctrl_wr, poke_wr, tick, run;
    logic [MODE_W-1:0] wr_mode;
    logic [LEN_W-1:0]  wr_len, len_q;
    logic [CNT_W-1:0]  wr_cnt, cnt_q;

    wdt_regif #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .CNT_W  (CNT_W)
    ) u_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .cnt_live  (cnt_q),
        .ctrl_wr   (ctrl_wr),
        .poke_wr   (poke_wr),
        .wr_mode   (wr_mode),
        .wr_len    (wr_len),
        .wr_cnt    (wr_cnt),
        .len_q     (len_q),
        .bus_rdata (bus_rdata)
    );

    wdt_prescaler #(
        .PRE_LOG2 (PRE_LOG2)
    ) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctrl_wr | poke_wr),
        .run  (run),
        .tick (tick)
    );

    wdt_fsm #(
        .LEN_W    (LEN_W),
        .CNT_W    (CNT_W),
        .PRE_LOG2 (PRE_LOG2)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ctrl_wr (ctrl_wr),
        .poke_wr (poke_wr),
        .wr_mode (wr_mode),
        .wr_len  (wr_len),
        .wr_cnt  (wr_cnt),
        .len_q   (len_q),
        .tick    (tick),
        .run     (run),
        .cnt_q   (cnt_q),
        .expire  (expire)
    );

endmodule

// File: tb/wdt_core_test.sv
`timescale 1ns/1ps
module wdt_core_test;

    localparam int PL2 = 2;
    localparam int P   = 1 << PL2;
    localparam logic [19:0] CTRL = 20'h00000;
    localparam logic [19:0] POKE = 20'h10000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        expire;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    wdt_core #(.PRE_LOG2(PL2)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .expire    (expire)
    );

    function automatic logic [63:0] ctrl_word(logic [1:0] m, logic [15:0] l, logic [23:0] c);
        return {20'h0, c, l, 2'b00, m};
    endfunction

    function automatic int exp_period(int n);
        return ((n == 0) ? 1 : n) * P;
    endfunction

    function automatic logic [23:0] exp_reload(logic [15:0] l);
        return {l, 8'h00};
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [19:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = CTRL; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [19:0] a, output logic [63:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_addr = CTRL;
    endtask

    task automatic wait_expire(input int limit, output int k, output bit seen);
        k = 0; seen = 1'b0;
        while (!seen && k < limit) begin
            @(posedge clk); @(negedge clk);
            k++;
            if (expire) seen = 1'b1;
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        int k;
        bit seen;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(expire == 1'b0, "R1 expire after reset", expire, 0);
        bus_read(CTRL, rd);
        check(rd == 64'h0, "R1 control after reset", rd, 0);

        // R2: field layout with junk in the unused bits, mode 0 keeps it idle
        for (int i = 0; i < 4; i++) begin
            logic [15:0] l = 16'($urandom);
            logic [23:0] c = 24'($urandom);
            logic [63:0] d = ctrl_word(2'd0, l, c) | {20'($urandom), 24'h0, 16'h0, 2'($urandom), 2'b00};
            bus_write(CTRL, d);
            bus_read(CTRL, rd);
            check(rd == ctrl_word(2'd0, l, c), "R2 control readback", rd, ctrl_word(2'd0, l, c));
            repeat (3 * P) @(negedge clk);
            bus_read(CTRL, rd);
            check(rd == ctrl_word(2'd0, l, c), "R3 mode 0 holds count", rd, ctrl_word(2'd0, l, c));
            bus_read(POKE, rd);
            check(rd == 64'h0, "R2 poke reads zero", rd, 0);
        end

        // R4: exact tick spacing
        bus_write(CTRL, ctrl_word(2'd3, 16'h0040, 24'd5));
        repeat (P - 1) @(negedge clk);
        bus_read(CTRL, rd);
        check(rd[43:20] == 24'd5, "R4 count before tick", rd[43:20], 5);
        @(negedge clk);
        bus_read(CTRL, rd);
        check(rd[43:20] == 24'd4, "R4 count after tick", rd[43:20], 4);
        repeat (P - 1) @(negedge clk);
        bus_read(CTRL, rd);
        check(rd[43:20] == 24'd4, "R4 count held between ticks", rd[43:20], 4);
        bus_write(CTRL, 64'h0);

        // R5 / R6 / R3: random arming words
        for (int i = 0; i < 6; i++) begin
            logic [1:0]  m = 2'($urandom_range(1, 3));
            logic [15:0] l = 16'($urandom_range(1, 16'hFFFF));
            int          n = (i == 0) ? 0 : $urandom_range(1, 40);
            bus_write(CTRL, ctrl_word(m, l, 24'(n)));
            wait_expire(45 * P, k, seen);
            check(seen && k == exp_period(n), $sformatf("R5 first period mode %0d (R3)", m), k, exp_period(n));
            bus_read(CTRL, rd);
            check(rd == ctrl_word(m, l, exp_reload(l)), "R6 reload at expiry", rd, ctrl_word(m, l, exp_reload(l)));
            @(negedge clk);
            check(expire == 1'b0, "R6 single-cycle pulse", expire, 0);
            bus_write(CTRL, 64'h0);
        end

        // R10: steady period after expiry
        bus_write(CTRL, ctrl_word(2'd3, 16'h0001, 24'd2));
        wait_expire(10 * P, k, seen);
        check(seen && k == exp_period(2), "R10 first expiry", k, exp_period(2));
        wait_expire(300 * P, k, seen);
        check(seen && k == 256 * P, "R10 reload period", k, 256 * P);
        bus_write(CTRL, 64'h0);

        // R7: poke mid-period with random data
        bus_write(CTRL, ctrl_word(2'd3, 16'h0001, 24'd100));
        repeat (2 * P + 1) @(negedge clk);
        bus_write(POKE, {$urandom, $urandom});
        bus_read(CTRL, rd);
        check(rd[43:20] == exp_reload(16'h0001), "R7 poke reloads count", rd[43:20], exp_reload(16'h0001));
        wait_expire(300 * P, k, seen);
        check(seen && k == 256 * P, "R7 period after poke", k, 256 * P);
        bus_read(POKE, rd);
        check(rd == 64'h0, "R7 poke reads zero", rd, 0);

        // R8: stop
        bus_write(CTRL, ctrl_word(2'd3, 16'h0002, 24'd3));
        repeat (P) @(negedge clk);
        bus_write(CTRL, 64'h0);
        wait_expire(50 * P, k, seen);
        check(!seen, "R8 no expiry after stop", seen, 0);
        bus_read(CTRL, rd);
        check(rd == 64'h0, "R8 control reads zero", rd, 0);

        // R9: zero length with nonzero mode stays idle
        bus_write(CTRL, ctrl_word(2'd3, 16'h0000, 24'd5));
        wait_expire(20 * P, k, seen);
        check(!seen, "R9 no expiry with zero length", seen, 0);
        bus_read(CTRL, rd);
        check(rd[43:20] == 24'd5, "R9 count frozen", rd[43:20], 5);

        // R3: mode 0 with nonzero length stays idle
        bus_write(CTRL, ctrl_word(2'd0, 16'h0003, 24'd2));
        wait_expire(20 * P, k, seen);
        check(!seen, "R3 mode 0 idle", seen, 0);

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule